// File: doc/BRIEF.md
# UART Receive Status and Interrupt Register

This block holds the status and interrupt state of one serial channel. It contains a receive FIFO whose entries carry a received character together with four per-character condition flags: break, frame error, parity error and overrun. The status register always shows the flags of the character at the head of the FIFO. It also shows the fill level and an active-low data-available bit. Popping the FIFO moves the displayed flags on to the next character.

Three sticky interrupt bits sit beside the status fields: a receive-error bit, a receive-timeout bit and a transmit-space bit. Software clears any of them by writing zero to its position. A single interrupt line is the OR of the three. The receiver pushes characters through a push port. The transmit side supplies its free-space count and the programmed trigger level.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset the register reads 0x0000_4100: FIFO empty (bit 14 = 1), transmit-space bit 8 = 1, all other bits 0.
- R2: Bits 31:16 and 7:5 always read 0.
- R3: Bit 14 reads 1 exactly when the FIFO holds no entry. Bits 4:0 give the number of stored entries, from 0 to 16.
- R4: Bits 15, 13, 12 and 11 show the break, frame, parity and overrun flags of the head entry, and `rx_data_o` shows its character. A pop advances them to the next entry. While the FIFO is empty they read 0.
- R5: A push while the FIFO holds 16 entries is dropped and the count stays 16. The overrun flag (bit 11 once that entry reaches the head) is set on the most recently stored entry.
- R6: Bit 10 becomes 1 in the cycle after a push that carries a frame, parity or overrun flag, or after a push that is dropped.
- R7: Bit 9 becomes 1 in the cycle after `rx_timeout_i` is high.
- R8: Bit 8 becomes 1 in the cycle after a cycle in which `tx_free_i >= tx_trig_i`.
- R9: A register write with 0 in bit 10, 9 or 8 clears that bit, and a 1 leaves it unchanged. If the bit's set event happens in the same cycle as a clearing write, the bit ends up 1.
- R10: Writes to bits 15:11 and 4:0 have no effect on what the register reads.
- R11: `irq_o` is 1 exactly when at least one of bits 10, 9 and 8 is 1.
- R12: A pop while the FIFO is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value |
| push_i | input | 1 | Push a received character |
| push_data_i | input | 8 | Received character |
| push_brk_i | input | 1 | Character was a break |
| push_fer_i | input | 1 | Character had a frame error |
| push_per_i | input | 1 | Character had a parity error |
| push_oer_i | input | 1 | Character had an overrun |
| pop_i | input | 1 | Remove the head entry |
| rx_data_o | output | 8 | Character at the head (0 if empty) |
| rx_timeout_i | input | 1 | Receive timeout pulse |
| tx_free_i | input | 5 | Transmit FIFO free entries |
| tx_trig_i | input | 5 | Transmit trigger level |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle: the fill count never exceeds the depth, a push into a full FIFO keeps it full, and a pop into an empty FIFO keeps it empty. They also check that head flags are zero while the FIFO is empty, and that each sticky bit obeys set-wins, hold-on-one and clear-on-zero. Three behaviours can only be shown by the bench's scenarios, which run against a queue model: that the displayed flags belong to the right entry after a series of pushes and pops, that the overrun mark falls on the last stored entry, and that writes to read-only fields leave the read value intact.

// File: rtl/uart_rx_stat_pkg.sv
package uart_rx_stat_pkg;
  typedef struct packed {
    logic       brk;
    logic       fer;
    logic       per;
    logic       oer;
    logic [7:0] data;
  } rx_ent_t;

  localparam int unsigned BIT_BRK   = 15;
  localparam int unsigned BIT_EMPTY = 14;
  localparam int unsigned BIT_FER   = 13;
  localparam int unsigned BIT_PER   = 12;
  localparam int unsigned BIT_OER   = 11;
  localparam int unsigned BIT_ERR   = 10;
  localparam int unsigned CNT_FW    = 5;
endpackage

// File: rtl/rx_flag_fifo.sv
module rx_flag_fifo
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_ent_t       ent_i,
  input  logic          pop_i,
  output rx_ent_t       head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          drop_o
);
  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, last_ptr;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign do_push  = push_i && !full;
  assign do_pop   = pop_i && !empty_o;
  assign drop_o   = push_i && full;
  assign last_ptr = (wptr_q == '0) ? AW'(DEPTH - 1) : wptr_q - AW'(1);

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= inc(wptr_q);
      if (do_pop)  rptr_q <= inc(rptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  // storage carries no reset; head is masked while empty
  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= ent_i;
    if (drop_o)  mem[last_ptr].oer <= 1'b1;
  end

  assign head_o  = empty_o ? '0 : mem[rptr_q];
  assign count_o = cnt_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (cnt_q == CW'(DEPTH)));
  p_pop_empty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (cnt_q == '0));
endmodule

// File: rtl/wzc_bits.sv
module wzc_bits #(
  parameter int unsigned     N       = 3,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set wins over clear
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[k] && !clr_i[k]) |=> q_o[k]);
    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !q_o[k]);
  end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TXW   = 5,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           push_i,
  input  logic [7:0]     push_data_i,
  input  logic           push_brk_i,
  input  logic           push_fer_i,
  input  logic           push_per_i,
  input  logic           push_oer_i,
  input  logic           pop_i,
  output logic [7:0]     rx_data_o,
  input  logic           rx_timeout_i,
  input  logic [TXW-1:0] tx_free_i,
  input  logic [TXW-1:0] tx_trig_i,
  output logic           irq_o
);
  rx_ent_t       ent, head;
  logic [CW-1:0] count;
  logic          empty, drop;
  logic [2:0]    irq_set, irq_clr, irq_q;   // {err, timeout, tx}

  assign ent = '{brk: push_brk_i, fer: push_fer_i, per: push_per_i,
                 oer: push_oer_i, data: push_data_i};

  rx_flag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i, .ent_i(ent), .pop_i,
    .head_o(head), .count_o(count), .empty_o(empty), .drop_o(drop)
  );

  assign irq_set[2] = (push_i && (push_fer_i || push_per_i || push_oer_i)) || drop;
  assign irq_set[1] = rx_timeout_i;
  assign irq_set[0] = (tx_free_i >= tx_trig_i);
  assign irq_clr    = {3{reg_we_i}} & ~reg_wdata_i[BIT_ERR -: 3];

  wzc_bits #(.N(3), .RST_VAL(3'b001)) u_irq (
    .clk_i, .rst_ni, .set_i(irq_set), .clr_i(irq_clr), .q_o(irq_q)
  );

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[BIT_BRK]   = head.brk;
    reg_rdata_o[BIT_EMPTY] = empty;
    reg_rdata_o[BIT_FER]   = head.fer;
    reg_rdata_o[BIT_PER]   = head.per;
    reg_rdata_o[BIT_OER]   = head.oer;
    reg_rdata_o[BIT_ERR -: 3] = irq_q;
    reg_rdata_o[CNT_FW-1:0]   = CNT_FW'(count);
  end

  assign rx_data_o = head.data;
  assign irq_o     = |irq_q;

  p_empty_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> (head == '0));
  p_timeout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_timeout_i |=> reg_rdata_o[9]);
endmodule

// File: tb/uart_rx_stat_test.sv
module uart_rx_stat_test;
  logic        clk = 0, rst_n = 0;
  logic        we = 0, push = 0, brk = 0, fer = 0, per = 0, oer = 0, pop = 0, tmo = 0;
  logic [31:0] wd = 0;
  logic [7:0]  pd = 0;
  logic [4:0]  tfree = 0, ttrig = 1;
  logic [31:0] rd;
  logic [7:0]  rxd;
  logic        irq;

  int checks = 0, errors = 0;
  logic [11:0] q[$];                // {brk,fer,per,oer,data}
  logic        m_err = 0, m_tmo = 0, m_tx = 1;

  always #5 clk = ~clk;

  uart_rx_stat uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .push_i(push), .push_data_i(pd), .push_brk_i(brk), .push_fer_i(fer),
    .push_per_i(per), .push_oer_i(oer), .pop_i(pop), .rx_data_o(rxd),
    .rx_timeout_i(tmo), .tx_free_i(tfree), .tx_trig_i(ttrig), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] head_m();
    return (q.size() == 0) ? 12'h0 : q[0];
  endfunction

  task automatic check_all();
    logic [11:0] h = head_m();
    chk("R2", {rd[31:16], 13'h0, rd[7:5]}, 32'h0);
    chk("R3", {rd[14], rd[4:0]}, {(q.size() == 0), 5'(q.size())});
    chk("R4", {rd[15], rd[13:11], rxd}, {h[11], h[10:8], h[7:0]});
    chk("R6", rd[10], m_err);
    chk("R7", rd[9], m_tmo);
    chk("R8", rd[8], m_tx);
    chk("R11", irq, m_err | m_tmo | m_tx);
  endtask

  // drive at negedge, update model at posedge, check at next negedge
  task automatic step(bit p_push, bit [11:0] e, bit p_pop, bit p_tmo,
                      bit p_we, bit [31:0] p_wd, bit [4:0] p_free, bit [4:0] p_trig);
    bit full;
    int pre;
    push = p_push; {brk, fer, per, oer, pd} = e; pop = p_pop; tmo = p_tmo;
    we = p_we; wd = p_wd; tfree = p_free; ttrig = p_trig;
    @(posedge clk);
    pre  = q.size();
    full = (pre == 16);
    m_err = (m_err & ~(p_we & ~p_wd[10])) | (p_push & ((|e[10:8]) | full));
    m_tmo = (m_tmo & ~(p_we & ~p_wd[9])) | p_tmo;
    m_tx  = (m_tx  & ~(p_we & ~p_wd[8])) | (p_free >= p_trig);
    if (p_push) begin
      if (!full) q.push_back(e);
      else q[q.size()-1][8] = 1'b1;
    end
    if (p_pop && pre > 0) void'(q.pop_front());
    @(negedge clk);
    push = 0; pop = 0; tmo = 0; we = 0;
    check_all();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", rd, 32'h0000_4100);
    check_all();

    // R12: pop on empty
    step(0, 0, 1, 0, 0, 0, 0, 1);
    chk("R12", rd[14:0] & 15'h401F, 15'h4000);

    // R9: clear tx bit with write of zero, then set wins over clear
    step(0, 0, 0, 0, 1, 32'h0000_0600, 0, 1);
    chk("R9", rd[8], 1'b0);
    step(0, 0, 0, 1, 1, 32'h0, 0, 1);
    chk("R9", rd[9], 1'b1);
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 1);
    chk("R9", rd[9], 1'b1);

    // R5: fill to 16, then overflow push marks last entry
    for (int i = 0; i < 16; i++) step(1, {4'b0000, 8'(i + 8'h30)}, 0, 0, 1, 32'h0, 0, 1);
    chk("R5", rd[4:0], 5'd16);
    step(1, 12'h0AA, 0, 0, 0, 0, 0, 1);
    chk("R5", rd[4:0], 5'd16);
    chk("R6", rd[10], 1'b1);
    // R10: write ones to read-only fields
    step(0, 0, 0, 0, 1, 32'hFFFF_F8FF, 0, 1);
    chk("R10", {rd[15:11], rd[4:0]}, {5'b0, 5'd16});
    for (int i = 0; i < 15; i++) step(0, 0, 1, 0, 0, 0, 0, 1);
    chk("R5", {rd[11], rxd}, {1'b1, 8'h3F});
    step(0, 0, 1, 0, 0, 0, 0, 1);

    // R4: break entry at head
    step(1, 12'h8_41, 0, 0, 0, 0, 0, 1);
    chk("R4", {rd[15], rxd}, {1'b1, 8'h41});

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int bias = ((n / 300) % 2) ? 70 : 30;
      bit pu = ($urandom % 100) < bias;
      bit po = ($urandom % 100) < (100 - bias);
      bit [11:0] e = 12'($urandom);
      if (($urandom % 4) != 0) e[11:8] = 4'b0;
      step(pu, e, po, ($urandom % 20) == 0, ($urandom % 6) == 0, $urandom,
           5'($urandom % 17), 5'(1 + $urandom % 16));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule